// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets a processor reach the registers of an Ethernet PHY over the two-wire management bus. Software sees six small registers: configuration, command, address, write data, read data and indicator. The block turns register writes into IEEE 802.3 clause-22 read and write frames on MDC and MDIO. MDC is made from the system clock by a divider whose ratio comes from a field in the configuration register.

Writing the write-data register starts a write frame at once. There is no separate command for a write. A read starts when software sets the read bit of the command register. Software has to clear that bit again before it can start the next read. The indicator register reports when a frame is in flight, when read data is not yet valid, and the link state taken from the PHY status register. A reset bit in the configuration register stops any frame in progress and clears the indicator flags.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the configuration register reads 0x0020, the indicator reads 0x0000, MDC is low and MDIO is not driven (`mdio_oe` low).
- R2: The address register (index 2) holds the PHY address in bits 12:8 and the PHY register number in bits 4:0. All other bits read back as zero.
- R3: Writing the write-data register (index 3) while idle sends one write frame, MSB first: 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the 16 written data bits.
- R4: A write of the command register (index 1) that sets bit 0 while bit 0 is currently clear, and while idle, sends a read frame with opcode 10. The block releases MDIO from the first turnaround bit through the last data bit, and it samples the PHY data on rising MDC.
- R5: BUSY (indicator bit 0) is high on the first clock after a frame is launched. It stays high until the frame ends.
- R6: NOTVALID (indicator bit 2) rises when a read is launched. It falls on the same clock as BUSY falls, and on that clock the read-data register (index 4) takes the 16 sampled bits. Outside that clock the read-data register holds its value.
- R7: While configuration bit 15 is set, any frame is aborted within one clock. BUSY, NOTVALID and LINKFAIL read zero, MDC stays low and MDIO is released.
- R8: Configuration bits 5:2 hold a divider select `s`. The MDC period is 4·s+8 system clocks. The reset value is s=8, which gives a period of 40.
- R9: A write-data write or a read request that arrives while BUSY is high starts no frame.
- R10: LINKFAIL (indicator bit 3) is updated when a read of PHY register 1 completes. It is set to the inverse of bit 2 of the returned data.
- R11: Command bit 1 (scan) is stored and reads back. It launches no frame and does not set BUSY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value (pulled high when undriven) |

## Verification
Some properties are checked by assertions on every cycle. NOTVALID is never high without BUSY. The read-data register changes only while a frame is in flight. A launch is always followed by BUSY. An abort leaves MDC low and MDIO released on the next clock. The bit counter advances only on falling MDC.

Other behaviour only the bench scenarios can show. The bench uses a PHY model that decodes every frame and compares it with a queue of expected frames. It checks the bit-exact frame contents and the MDC period for two divider settings. It also checks that launches made while busy or through the scan bit start no frame. Finally it checks that LINKFAIL follows the status-register data, and that read data arrives on the exact clock BUSY falls.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int DATA_W = 16;
   localparam int ADDR_W = 5;

   // register indices seen by software
   localparam logic [2:0] RA_CFG   = 3'd0;
   localparam logic [2:0] RA_CMD   = 3'd1;
   localparam logic [2:0] RA_ADDR  = 3'd2;
   localparam logic [2:0] RA_WDATA = 3'd3;
   localparam logic [2:0] RA_RDATA = 3'd4;
   localparam logic [2:0] RA_IND   = 3'd5;

   // field positions
   localparam int CFG_RST_BIT  = 15;
   localparam int CFG_SEL_LSB  = 2;
   localparam int CMD_READ_BIT = 0;
   localparam int CMD_SCAN_BIT = 1;
   localparam int ADDR_PHY_LSB = 8;
   localparam int IND_BUSY_BIT = 0;
   localparam int IND_NV_BIT   = 2;
   localparam int IND_LF_BIT   = 3;

   // PHY status register and its link bit
   localparam logic [ADDR_W-1:0] PHY_STATUS_REG = 5'd1;
   localparam int                PHY_LINK_BIT   = 2;

   typedef struct packed {
      logic              is_read;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regn;
      logic [DATA_W-1:0] wdata;
   } mdio_req_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             mdc,
   output logic             rise_tick,
   output logic             fall_tick
);
   // half period = 2*sel + 4 clocks
   localparam int CNT_W = SEL_W + 3;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;
   logic             wrap;

   always_comb begin
      half_m1   = CNT_W'({sel, 1'b0}) + CNT_W'(3);
      wrap      = en && (cnt_q == half_m1);
      rise_tick = wrap && !mdc;
      fall_tick = wrap && mdc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc   <= !mdc;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // R8: the clock rests low whenever the divider is off
   a_r8_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !mdc);
   // R8: a single edge event per clock
   a_r8_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise_tick, fall_tick}));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_BITS = 32,
   parameter int IN_SYNC  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  mdio_req_t         req,
   input  logic              mdc_rise,
   input  logic              mdc_fall,
   input  logic              mdio_i,
   output logic              busy,
   output logic              done_read,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] cur_reg,
   output logic              mdio_o,
   output logic              mdio_oe
);
   localparam int FRAME_W = PRE_BITS + 32;
   localparam int IDX_W   = $clog2(FRAME_W + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_BITS + 14);
   localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_BITS + 16);

   logic [FRAME_W-1:0] sh_q;
   logic [FRAME_W-1:0] load_v;
   logic [IDX_W-1:0]   idx_q;
   logic               rd_q;
   logic [DATA_W-1:0]  cap_q;
   logic               din;
   logic               last_fall;

   generate
      if (IN_SYNC == 0) begin : g_direct
         assign din = mdio_i;
      end else begin : g_sync
         logic [IN_SYNC-1:0] s_q;
         always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '1;
            else        s_q <= (s_q << 1) | IN_SYNC'(mdio_i);
         end
         assign din = s_q[IN_SYNC-1];
      end
   endgenerate

   always_comb begin
      load_v = {{PRE_BITS{1'b1}}, 2'b01,
                req.is_read ? 2'b10 : 2'b01,
                req.phy, req.regn,
                req.is_read ? 2'b11 : 2'b10,
                req.is_read ? {DATA_W{1'b1}} : req.wdata};
      last_fall = busy && mdc_fall && (idx_q == LAST_IDX);
      done_read = last_fall && rd_q && !abort;
      rd_data   = cap_q;
      mdio_o    = busy ? sh_q[FRAME_W-1] : 1'b1;
      mdio_oe   = busy && !(rd_q && (idx_q >= TA_IDX));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sh_q    <= '1;
         idx_q   <= '0;
         rd_q    <= 1'b0;
         cap_q   <= '0;
         cur_reg <= '0;
      end else if (abort) begin
         busy  <= 1'b0;
         sh_q  <= '1;
         idx_q <= '0;
         rd_q  <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            busy    <= 1'b1;
            sh_q    <= load_v;
            idx_q   <= '0;
            rd_q    <= req.is_read;
            cur_reg <= req.regn;
         end
      end else begin
         if (mdc_rise && rd_q && (idx_q >= DATA_IDX))
            cap_q <= {cap_q[DATA_W-2:0], din};
         if (mdc_fall) begin
            if (idx_q == LAST_IDX) begin
               busy <= 1'b0;
               rd_q <= 1'b0;
            end else begin
               sh_q  <= {sh_q[FRAME_W-2:0], 1'b1};
               idx_q <= idx_q + IDX_W'(1);
            end
         end
      end
   end

   // R3: the bit position only moves on a falling management clock
   a_r3_idx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !abort && !mdc_fall |=> $stable(idx_q));
   // R4: the line is released on the last bit of a read frame
   a_r4_release_end: assert property (@(posedge clk) disable iff (!rst_n)
      done_read |-> !mdio_oe);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_BITS      = 32,
   parameter int SEL_W         = 4,
   parameter int IN_SYNC       = 2,
   parameter int CFG_RESET_SEL = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  reg_addr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   generate
      if (PRE_BITS < 1 || PRE_BITS > 64) begin : g_bad_pre
         $error("PRE_BITS out of range");
      end
      if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel
         $error("SEL_W out of range");
      end
      if (IN_SYNC < 0 || IN_SYNC > 3) begin : g_bad_sync
         $error("IN_SYNC must stay below the shortest half period");
      end
      if (CFG_RESET_SEL < 0 || CFG_RESET_SEL >= (1 << SEL_W)) begin : g_bad_rst
         $error("CFG_RESET_SEL does not fit SEL_W");
      end
   endgenerate

   logic                 cfg_rst_q;
   logic [SEL_W-1:0]     sel_q;
   logic [1:0]           cmd_q;
   logic [ADDR_W-1:0]    phy_q, reg_q;
   logic [DATA_W-1:0]    wdata_q, rdata_q;
   logic                 nv_q, lf_q;

   logic                 busy, done_read, mdc_rise, mdc_fall;
   logic                 launch_rd, launch_wr, start, div_en;
   logic [DATA_W-1:0]    eng_rd;
   logic [ADDR_W-1:0]    eng_reg;
   mdio_req_t            req;

   always_comb begin
      launch_wr = reg_wr && (reg_addr == RA_WDATA) && !busy && !cfg_rst_q;
      launch_rd = reg_wr && (reg_addr == RA_CMD) && reg_wdata[CMD_READ_BIT]
                  && !cmd_q[CMD_READ_BIT] && !busy && !cfg_rst_q;
      start       = launch_wr || launch_rd;
      req.is_read = launch_rd;
      req.phy     = phy_q;
      req.regn    = reg_q;
      req.wdata   = reg_wdata;
      div_en      = busy && !cfg_rst_q;
   end

   mdio_clk_div #(.SEL_W(SEL_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (div_en),
      .sel       (sel_q),
      .mdc       (mdc),
      .rise_tick (mdc_rise),
      .fall_tick (mdc_fall)
   );

   mdio_frame_engine #(.PRE_BITS(PRE_BITS), .IN_SYNC(IN_SYNC)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort     (cfg_rst_q),
      .start     (start),
      .req       (req),
      .mdc_rise  (mdc_rise),
      .mdc_fall  (mdc_fall),
      .mdio_i    (mdio_i),
      .busy      (busy),
      .done_read (done_read),
      .rd_data   (eng_rd),
      .cur_reg   (eng_reg),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_rst_q <= 1'b0;
         sel_q     <= SEL_W'(CFG_RESET_SEL);
         cmd_q     <= '0;
         phy_q     <= '0;
         reg_q     <= '0;
         wdata_q   <= '0;
         rdata_q   <= '0;
         nv_q      <= 1'b0;
         lf_q      <= 1'b0;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               RA_CFG: begin
                  cfg_rst_q <= reg_wdata[CFG_RST_BIT];
                  sel_q     <= reg_wdata[CFG_SEL_LSB +: SEL_W];
               end
               RA_CMD:   cmd_q   <= reg_wdata[1:0];
               RA_ADDR: begin
                  phy_q <= reg_wdata[ADDR_PHY_LSB +: ADDR_W];
                  reg_q <= reg_wdata[ADDR_W-1:0];
               end
               RA_WDATA: wdata_q <= reg_wdata;
               default: ;
            endcase
         end
         if (cfg_rst_q) begin
            nv_q <= 1'b0;
            lf_q <= 1'b0;
         end else if (launch_rd) begin
            nv_q <= 1'b1;
         end else if (done_read) begin
            nv_q    <= 1'b0;
            rdata_q <= eng_rd;
            if (eng_reg == PHY_STATUS_REG)
               lf_q <= !eng_rd[PHY_LINK_BIT];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CFG: begin
            reg_rdata[CFG_RST_BIT]              = cfg_rst_q;
            reg_rdata[CFG_SEL_LSB +: SEL_W]     = sel_q;
         end
         RA_CMD:   reg_rdata[1:0] = cmd_q;
         RA_ADDR: begin
            reg_rdata[ADDR_PHY_LSB +: ADDR_W] = phy_q;
            reg_rdata[ADDR_W-1:0]             = reg_q;
         end
         RA_WDATA: reg_rdata = wdata_q;
         RA_RDATA: reg_rdata = rdata_q;
         RA_IND: begin
            reg_rdata[IND_BUSY_BIT] = busy;
            reg_rdata[IND_NV_BIT]   = nv_q;
            reg_rdata[IND_LF_BIT]   = lf_q;
         end
         default: ;
      endcase
   end

   // R5: a launch shows BUSY on the next clock
   a_r5_busy_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R6: NOTVALID never outlives BUSY
   a_r6_nv_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      nv_q |-> busy);
   // R6: read data only changes while a frame is in flight
   a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(rdata_q));
   // R7: abort silences the bus on the next clock
   a_r7_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rst_q |=> (!busy && !mdc && !mdio_oe && !nv_q && !lf_q));

endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   always #2.5 clk = !clk;

   mdio_mgmt_master dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   typedef struct {
      bit        rd;
      bit [4:0]  phy;
      bit [4:0]  rg;
      bit [15:0] d;
   } exp_t;

   exp_t        sbq[$];
   logic [15:0] phy_regs [32];
   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   int          pcnt = 0;
   bit          cur_rd = 0;
   bit          oe_bad = 0;
   logic [63:0] cap = '0;
   logic [15:0] rdval = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [15:0] v;
      for (int i = 0; i < 20000; i++) begin
         reg_read(3'd5, v);
         if (!v[0]) return;
         @(negedge clk);
      end
   endtask

   task automatic mdc_period(output int p);
      int t0;
      @(posedge mdc); t0 = cyc;
      @(posedge mdc); p = cyc - t0;
   endtask

   // PHY model and scoreboard monitor
   initial begin
      forever begin
         @(posedge mdc);
         cap = {cap[62:0], (mdio_oe ? mdio_o : mdio_i)};
         if (cur_rd && pcnt >= 46 && mdio_oe) oe_bad = 1;
         pcnt++;
         if (pcnt == 46) begin
            cur_rd = (cap[11:10] == 2'b10);
            rdval  = phy_regs[cap[4:0]];
            oe_bad = 0;
         end
         if (cur_rd && pcnt >= 48 && pcnt <= 63) begin
            #1;
            mdio_i = rdval[63-pcnt];
         end
         if (pcnt == 64) begin
            if (sbq.size() == 0) begin
               chk("R9 unexpected frame", 1, 0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               chk(e.rd ? "R4 preamble" : "R3 preamble", cap[63:32], 32'hFFFF_FFFF);
               chk(e.rd ? "R4 start" : "R3 start", cap[31:30], 2'b01);
               chk(e.rd ? "R4 opcode" : "R3 opcode", cap[29:28], e.rd ? 2'b10 : 2'b01);
               chk(e.rd ? "R4 phy addr" : "R3 phy addr", cap[27:23], e.phy);
               chk(e.rd ? "R4 reg addr" : "R3 reg addr", cap[22:18], e.rg);
               if (e.rd) begin
                  chk("R4 released from turnaround", oe_bad, 0);
               end else begin
                  chk("R3 turnaround", cap[17:16], 2'b10);
                  chk("R3 data", cap[15:0], e.d);
               end
            end
            mdio_i = 1'b1;
            pcnt   = 0;
            cur_rd = 0;
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      logic [15:0] v, prev;
      int p;
      exp_t e;
      for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_read(3'd0, v); chk("R1 cfg reset", v, 16'h0020);
      reg_read(3'd5, v); chk("R1 indicator reset", v, 16'h0000);
      chk("R1 mdc low", mdc, 0);
      chk("R1 mdio released", mdio_oe, 0);

      // R2 address fields
      reg_write(3'd2, 16'hFFFF);
      reg_read(3'd2, v); chk("R2 address mask", v, 16'h1F1F);
      reg_write(3'd2, 16'h0511);
      reg_read(3'd2, v); chk("R2 address readback", v, 16'h0511);

      // R3 write frame, R5 busy, R8 period at reset divider
      e.rd = 0; e.phy = 5'h05; e.rg = 5'h11; e.d = 16'hBEEF;
      sbq.push_back(e);
      reg_write(3'd3, 16'hBEEF);
      reg_read(3'd5, v); chk("R5 busy after write launch", v[0], 1);
      mdc_period(p); chk("R8 period select 8", p, 40);
      // R9 launches while busy are ignored
      reg_write(3'd3, 16'h1234);
      reg_write(3'd1, 16'h0001);
      reg_read(3'd5, v); chk("R9 no notvalid while busy", v[2], 0);
      wait_idle();
      repeat (300) @(negedge clk);
      chk("R9 no extra frame", sbq.size(), 0);
      reg_write(3'd1, 16'h0000);

      // R4 read frame, R6 data timing, R8 fastest divider
      reg_write(3'd0, 16'h0000);
      reg_write(3'd2, 16'h0307);
      phy_regs[7] = 16'hC35A;
      e.rd = 1; e.phy = 5'h03; e.rg = 5'h07; e.d = 16'hC35A;
      sbq.push_back(e);
      reg_write(3'd1, 16'h0001);
      reg_read(3'd5, v); chk("R5 R6 busy and notvalid at read", v, 16'h0005);
      mdc_period(p); chk("R8 period select 0", p, 8);
      prev = v;
      for (int i = 0; i < 20000; i++) begin
         reg_read(3'd5, v);
         if (!v[0]) break;
         prev = v;
         @(negedge clk);
      end
      chk("R6 notvalid high until last busy cycle", prev, 16'h0005);
      chk("R6 notvalid drops with busy", v, 16'h0000);
      reg_read(3'd4, v); chk("R6 read data", v, 16'hC35A);
      reg_write(3'd1, 16'h0000);

      // R10 link fail from status register
      reg_write(3'd2, 16'h0301);
      phy_regs[1] = 16'h0000;
      e.rd = 1; e.phy = 5'h03; e.rg = 5'h01; e.d = 16'h0000;
      sbq.push_back(e);
      reg_write(3'd1, 16'h0001);
      wait_idle();
      reg_read(3'd5, v); chk("R10 link down", v, 16'h0008);
      reg_write(3'd1, 16'h0000);
      phy_regs[1] = 16'h0004;
      sbq.push_back(e);
      reg_write(3'd1, 16'h0001);
      wait_idle();
      reg_read(3'd5, v); chk("R10 link up", v, 16'h0000);
      reg_write(3'd1, 16'h0000);

      // R11 scan bit
      reg_write(3'd1, 16'h0002);
      reg_read(3'd1, v); chk("R11 scan readback", v, 16'h0002);
      reg_read(3'd5, v); chk("R11 scan no busy", v[0], 0);
      reg_write(3'd1, 16'h0000);

      // R7 abort: set link fail, start a read, then abort
      phy_regs[1] = 16'h0000;
      sbq.push_back(e);
      reg_write(3'd1, 16'h0001);
      wait_idle();
      reg_write(3'd1, 16'h0000);
      reg_write(3'd1, 16'h0001);
      repeat (100) @(negedge clk);
      reg_write(3'd0, 16'h8000);
      @(negedge clk);
      reg_read(3'd5, v); chk("R7 indicator cleared", v, 16'h0000);
      chk("R7 mdc low", mdc, 0);
      chk("R7 mdio released", mdio_oe, 0);
      reg_read(3'd0, v); chk("R7 cfg readback", v, 16'h8000);
      reg_write(3'd1, 16'h0000);
      reg_write(3'd0, 16'h0000);
      pcnt = 0; cur_rd = 0; mdio_i = 1'b1;
      // recovery after abort
      reg_write(3'd2, 16'h1F1E);
      e.rd = 0; e.phy = 5'h1F; e.rg = 5'h1E; e.d = 16'h8001;
      sbq.push_back(e);
      reg_write(3'd3, 16'h8001);
      wait_idle();
      repeat (50) @(negedge clk);
      chk("R9 scoreboard drained", sbq.size(), 0);
      finish_run();
   end
endmodule